// File: doc/BRIEF.md
# Timebase and Watchdog Timer

The block runs a free counter on the main oscillator clock and raises a periodic interrupt at one of four tap intervals. A sticky flag records each selected tap edge. The interrupt output shows that flag only while software enables it, and software removes the flag with a clear pulse.

The same counter taps drive a watchdog. Once software starts the watchdog, it can only be kept quiet by regular clear pulses. If four watchdog tap edges pass without a clear, the block raises a reset request that stays high until the system reset arrives. At start, the watchdog can take its tap from the main counter or from a second counter. That second counter advances on a slow sub-clock tick strobe, which is synchronous to the main clock.

Top module: `timebase_watchdog`

## Requirements
- R1: After synchronous reset, `irq` and `rst_req` are 0, both counters are zero and the watchdog is stopped.
- R2: The main counter advances on every clock. Tap k (log2 interval 12, 14, 16, 19 for `ivl_sel` = 0, 1, 2, 3) has its first edge 2^(k-1) cycles after the counter is zeroed, and then one edge every 2^k cycles.
- R3: The interrupt flag sets on an edge of the tap chosen by `ivl_sel` and stays set until a `flag_clr` pulse clears it.
- R4: `irq` is the flag ANDed with `irq_en`. Changing `irq_en` never alters the flag.
- R5: When a tap edge and `flag_clr` fall in the same cycle, the flag ends up set.
- R6: A `wd_start` pulse while the watchdog is stopped starts it with a zero count and latches `wd_sel` and `wd_src_sub` (1 selects the sub counter). While the watchdog runs, further starts and changes to these inputs have no effect.
- R7: Software cannot stop a running watchdog. Only reset stops it.
- R8: A running watchdog counts edges of its latched tap. `rst_req` rises on the fourth edge after the start or after the last `wd_kick`. If the watchdog is started together with `tb_clr`, this takes exactly 3.5 tap periods.
- R9: The sub counter advances only on cycles with `sub_tick` = 1. Its taps are log2 12, 15, 16, 17 for `wd_sel` = 0 to 3. Without ticks, a sub-sourced watchdog never fires.
- R10: When `wd_kick` and a watchdog tap edge fall in the same cycle, the count ends at zero.
- R11: `rst_req` stays high until reset, whatever the other inputs do.
- R12: `tb_clr` zeroes the main counter and suppresses tap edges in that cycle. This restarts the phase of both the interrupt tap and the main watchdog tap. `wd_kick` while the watchdog is stopped is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_tick | input | 1 | One-cycle strobe per sub-clock period |
| ivl_sel | input | 2 | Interrupt tap select |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Interrupt flag clear pulse |
| tb_clr | input | 1 | Main counter clear pulse |
| wd_start | input | 1 | Watchdog start pulse |
| wd_kick | input | 1 | Watchdog clear pulse |
| wd_sel | input | 2 | Watchdog tap select, latched at start |
| wd_src_sub | input | 1 | Watchdog source, 1 = sub counter, latched at start |
| irq | output | 1 | Interval interrupt |
| rst_req | output | 1 | Sticky watchdog reset request |

## Verification
Two pairs of events can collide. A tap edge can meet a flag clear, and a watchdog tap edge can meet a watchdog kick. Both collisions are forced on purpose. After a counter clear the tap phase is known exactly, so the clear pulses can be placed on the predicted edge cycles. The bench then checks that the flag survives, and that the reset request arrives only at the later time that follows from the count restarting at zero. Random stimulus adds many unplanned collisions, which a cycle model in the bench judges.

// File: rtl/tbwd_pkg.sv
package tbwd_pkg;

    localparam int unsigned N_TAPS   = 4;
    localparam int unsigned SEL_W    = $clog2(N_TAPS);
    localparam int unsigned WD_CNT_W = 2;
    localparam logic [WD_CNT_W-1:0] WD_LAST = '1;

    typedef enum logic {
        SRC_MAIN = 1'b0,
        SRC_SUB  = 1'b1
    } wd_src_e;

    typedef struct packed {
        wd_src_e            src;
        logic [SEL_W-1:0]   sel;
    } wd_cfg_t;

    typedef struct packed {
        logic                running;
        logic                fired;
        logic [WD_CNT_W-1:0] cnt;
        wd_cfg_t             cfg;
    } wd_state_t;

    function automatic logic pick_tap(input logic [N_TAPS-1:0] taps,
                                      input logic [SEL_W-1:0]  sel);
        return taps[sel];
    endfunction

endpackage

// File: rtl/tbwd_prescaler.sv
module tbwd_prescaler
    import tbwd_pkg::*;
#(
    parameter int unsigned TAP0 = 12,
    parameter int unsigned TAP1 = 14,
    parameter int unsigned TAP2 = 16,
    parameter int unsigned TAP3 = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              clr,
    output logic [N_TAPS-1:0] tap_evt
);
    localparam int unsigned TAP_LOG [N_TAPS] = '{TAP0, TAP1, TAP2, TAP3};
    localparam int unsigned CNT_W = TAP3;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (clr) cnt <= '0;
        else if (adv) cnt <= cnt + 1'b1;
    end

    // Each tap edge is the cycle in which counter bit K-1 is about to rise.
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        localparam int unsigned K = TAP_LOG[g];
        localparam logic [K-1:0] PRE_EDGE = K'((64'd1 << (K - 1)) - 64'd1);
        assign tap_evt[g] = adv && !clr && (cnt[K-1:0] == PRE_EDGE);
    end

    // R12: a clear leaves the counter at zero
    p_clr_zero_r12: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));
    // R2: taps of different lengths never fire together
    p_tap_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tap_evt));
    // R9: without an advance the counter holds
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clr) |=> $stable(cnt));

endmodule

// File: rtl/tbwd_irq.sv
module tbwd_irq
    import tbwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TAPS-1:0] tap_evt,
    input  logic [SEL_W-1:0]  sel,
    input  logic              flag_clr,
    input  logic              irq_en,
    output logic              irq
);
    logic flag;
    logic hit;

    assign hit = pick_tap(tap_evt, sel);

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (hit)      flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    assign irq = flag & irq_en;

    // R5: a tap edge beats a simultaneous clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (hit && flag_clr) |=> flag);
    // R3: flag holds until cleared
    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);
    // R3: a clear without an edge empties the flag
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !hit) |=> !flag);

endmodule

// File: rtl/tbwd_watchdog.sv
module tbwd_watchdog
    import tbwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TAPS-1:0] main_evt,
    input  logic [N_TAPS-1:0] sub_evt,
    input  logic              start,
    input  logic              kick,
    input  wd_cfg_t           cfg_in,
    output logic              rst_req
);
    wd_state_t st;
    logic      evt;

    assign evt = (st.cfg.src == SRC_SUB) ? pick_tap(sub_evt,  st.cfg.sel)
                                         : pick_tap(main_evt, st.cfg.sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (!st.running) begin
            if (start) begin
                st.running <= 1'b1;
                st.cnt     <= '0;
                st.cfg     <= cfg_in;
            end
        end else if (!st.fired) begin
            if (kick) begin
                st.cnt <= '0;
            end else if (evt) begin
                if (st.cnt == WD_LAST) st.fired <= 1'b1;
                else                   st.cnt   <= st.cnt + 1'b1;
            end
        end
    end

    assign rst_req = st.fired;

    // R6: configuration is frozen while running
    p_cfg_locked_r6: assert property (@(posedge clk) disable iff (rst)
        st.running |=> $stable(st.cfg));
    // R7: nothing but reset stops the watchdog
    p_no_stop_r7: assert property (@(posedge clk) disable iff (rst)
        st.running |=> st.running);
    // R10: a kick always leaves a zero count
    p_kick_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (st.running && !st.fired && kick) |=> (st.cnt == '0 && !st.fired));
    // R11: the request is sticky
    p_req_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        st.fired |=> st.fired);
    // R8: firing follows the full count
    p_fire_count_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(st.fired) |-> ($past(st.cnt) == WD_LAST));

endmodule

// File: rtl/timebase_watchdog.sv
module timebase_watchdog
    import tbwd_pkg::*;
#(
    parameter int unsigned MAIN_TAP0 = 12,
    parameter int unsigned MAIN_TAP1 = 14,
    parameter int unsigned MAIN_TAP2 = 16,
    parameter int unsigned MAIN_TAP3 = 19,
    parameter int unsigned SUB_TAP0  = 12,
    parameter int unsigned SUB_TAP1  = 15,
    parameter int unsigned SUB_TAP2  = 16,
    parameter int unsigned SUB_TAP3  = 17
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sub_tick,
    input  logic [1:0] ivl_sel,
    input  logic       irq_en,
    input  logic       flag_clr,
    input  logic       tb_clr,
    input  logic       wd_start,
    input  logic       wd_kick,
    input  logic [1:0] wd_sel,
    input  logic       wd_src_sub,
    output logic       irq,
    output logic       rst_req
);
    logic [N_TAPS-1:0] main_evt;
    logic [N_TAPS-1:0] sub_evt;
    wd_cfg_t           wd_cfg_req;

    assign wd_cfg_req.src = wd_src_e'(wd_src_sub);
    assign wd_cfg_req.sel = wd_sel;

    tbwd_prescaler #(
        .TAP0(MAIN_TAP0), .TAP1(MAIN_TAP1), .TAP2(MAIN_TAP2), .TAP3(MAIN_TAP3)
    ) i_main_cnt (
        .clk     (clk),
        .rst     (rst),
        .adv     (1'b1),
        .clr     (tb_clr),
        .tap_evt (main_evt)
    );

    tbwd_prescaler #(
        .TAP0(SUB_TAP0), .TAP1(SUB_TAP1), .TAP2(SUB_TAP2), .TAP3(SUB_TAP3)
    ) i_sub_cnt (
        .clk     (clk),
        .rst     (rst),
        .adv     (sub_tick),
        .clr     (1'b0),
        .tap_evt (sub_evt)
    );

    tbwd_irq i_irq (
        .clk      (clk),
        .rst      (rst),
        .tap_evt  (main_evt),
        .sel      (ivl_sel),
        .flag_clr (flag_clr),
        .irq_en   (irq_en),
        .irq      (irq)
    );

    tbwd_watchdog i_wdog (
        .clk      (clk),
        .rst      (rst),
        .main_evt (main_evt),
        .sub_evt  (sub_evt),
        .start    (wd_start),
        .kick     (wd_kick),
        .cfg_in   (wd_cfg_req),
        .rst_req  (rst_req)
    );

    // R1: outputs quiet in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!irq && !rst_req));

endmodule

// File: tb/test_timebase_watchdog.sv
`timescale 1ns/1ps
module test_timebase_watchdog;

    localparam int MT [4] = '{3, 4, 5, 6};
    localparam int ST [4] = '{2, 3, 4, 5};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sub_tick = 0, irq_en = 0, flag_clr = 0, tb_clr = 0;
    logic wd_start = 0, wd_kick = 0, wd_src_sub = 0;
    logic [1:0] ivl_sel = 0, wd_sel = 0;
    logic irq, rst_req;

    int nchk = 0, nfail = 0;
    bit done = 0;
    bit sb_on = 0;

    always #10 clk = ~clk;

    timebase_watchdog #(
        .MAIN_TAP0(MT[0]), .MAIN_TAP1(MT[1]), .MAIN_TAP2(MT[2]), .MAIN_TAP3(MT[3]),
        .SUB_TAP0(ST[0]),  .SUB_TAP1(ST[1]),  .SUB_TAP2(ST[2]),  .SUB_TAP3(ST[3])
    ) i_timebase_watchdog (
        .clk(clk), .rst(rst), .sub_tick(sub_tick), .ivl_sel(ivl_sel),
        .irq_en(irq_en), .flag_clr(flag_clr), .tb_clr(tb_clr),
        .wd_start(wd_start), .wd_kick(wd_kick), .wd_sel(wd_sel),
        .wd_src_sub(wd_src_sub), .irq(irq), .rst_req(rst_req)
    );

    // ---------------- behavioural model from the requirements ----------------
    int unsigned m_cnt, s_cnt;
    bit m_flag, m_run, m_fired, m_src;
    int m_wc, m_wsel;

    function automatic bit edge_due(int unsigned c, int k);
        return (c % (32'd1 << k)) == ((32'd1 << (k - 1)) - 1);
    endfunction

    always @(posedge clk) begin
        bit em [4];
        bit es [4];
        bit wev;
        if (rst) begin
            m_cnt = 0; s_cnt = 0; m_flag = 0; m_run = 0; m_fired = 0;
            m_wc = 0; m_wsel = 0; m_src = 0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                em[i] = !tb_clr && edge_due(m_cnt, MT[i]);
                es[i] = sub_tick && edge_due(s_cnt, ST[i]);
            end
            m_cnt = tb_clr ? 0 : (m_cnt + 1) % (32'd1 << MT[3]);
            if (sub_tick) s_cnt = (s_cnt + 1) % (32'd1 << ST[3]);
            if (em[ivl_sel]) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (!m_run) begin
                if (wd_start) begin
                    m_run = 1; m_wc = 0; m_wsel = int'(wd_sel); m_src = wd_src_sub;
                end
            end else if (!m_fired) begin
                wev = m_src ? es[m_wsel] : em[m_wsel];
                if (wd_kick) m_wc = 0;
                else if (wev) begin
                    if (m_wc == 3) m_fired = 1;
                    else m_wc++;
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (sb_on && !rst) begin
            chk("R3/R4/R5 irq vs model", int'(irq), int'(m_flag && irq_en));
            chk("R8/R9/R10 rst_req vs model", int'(rst_req), int'(m_fired));
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1; sub_tick = 0; flag_clr = 0; tb_clr = 0;
        wd_start = 0; wd_kick = 0; wd_src_sub = 0; wd_sel = 0;
        tick(); tick();
        rst = 0;
    endtask

    // expected delay to the first tap edge after a counter clear
    function automatic int first_edge(int k);
        return 1 << (k - 1);
    endfunction

    initial begin
        #(20ns * 200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'h1d2c3b4a));

        // R1: reset state
        do_reset();
        irq_en = 1;
        #1;
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 rst_req after reset", int'(rst_req), 0);

        // R2/R12: phase after a counter clear, ivl_sel = 1
        ivl_sel = 1; tb_clr = 1; flag_clr = 1;
        tick();
        tb_clr = 0; flag_clr = 0;
        n = 0;
        do begin tick(); n++; end while (!irq && n < 200);
        chk("R2/R12 first tap edge after clear", n, first_edge(MT[1]));
        flag_clr = 1; tick(); n++; flag_clr = 0;
        chk("R3 flag cleared by pulse", int'(irq), 0);
        do begin tick(); n++; end while (!irq && n < 200);
        chk("R2 second tap edge", n, first_edge(MT[1]) + (1 << MT[1]));
        flag_clr = 1; tick(); n++; flag_clr = 0;
        chk("R3 clear before collision", int'(irq), 0);
        // R5: clear held on the next edge cycle
        while (n < first_edge(MT[1]) + 2 * (1 << MT[1]) - 1) begin tick(); n++; end
        chk("R3 no early edge", int'(irq), 0);
        flag_clr = 1; tick(); n++; flag_clr = 0;
        chk("R5 edge beats clear", int'(irq), 1);
        tick(); tick(); tick();
        chk("R3 flag sticky", int'(irq), 1);
        irq_en = 0; #1;
        chk("R4 irq masked", int'(irq), 0);
        tick();
        irq_en = 1; #1;
        chk("R4 flag kept while masked", int'(irq), 1);

        // R6/R7/R8/R12: watchdog started with counter clear, then reconfig attempts
        do_reset();
        wd_kick = 1; tick();              // R12: kick while stopped is ignored
        wd_kick = 0;
        tb_clr = 1; wd_start = 1; wd_sel = 0; wd_src_sub = 0;
        tick();
        n = 0;
        tb_clr = 0; wd_sel = 3; wd_src_sub = 1;   // start still high: must be ignored
        tick(); n++;
        wd_start = 0;
        while (!rst_req && n < 400) begin tick(); n++; end
        chk("R6/R7/R8 reset after 3.5 tap periods", n, 7 * (1 << MT[0]) / 2);
        wd_kick = 1;
        repeat (10) tick();
        wd_kick = 0;
        chk("R11 request sticky", int'(rst_req), 1);

        // R10: kick lands on the first three tap edges
        do_reset();
        tb_clr = 1; wd_start = 1; wd_sel = 0; wd_src_sub = 0;
        tick();
        tb_clr = 0; wd_start = 0;
        n = 0;
        while (!rst_req && n < 400) begin
            wd_kick = (n == 3 || n == 11 || n == 19);
            tick(); n++;
        end
        wd_kick = 0;
        chk("R10 kick wins over tap edge", n, 7 * (1 << MT[0]) / 2 + 3 * (1 << MT[0]));

        // R9: sub source without ticks never fires
        do_reset();
        wd_start = 1; wd_src_sub = 1; wd_sel = 0; sub_tick = 0;
        tick(); wd_start = 0;
        repeat (300) tick();
        chk("R9 no sub ticks no reset", int'(rst_req), 0);

        // R9: sub source with a tick every cycle, counter zero at start
        do_reset();
        wd_start = 1; wd_src_sub = 1; wd_sel = 0; sub_tick = 1;
        tick(); wd_start = 0;
        n = 0;
        while (!rst_req && n < 400) begin tick(); n++; end
        chk("R9 sub reset delay", n, first_edge(ST[0]) - 1 + 3 * (1 << ST[0]));

        // random phase: model scoreboard
        do_reset();
        sb_on = 1;
        for (int c = 0; c < 20000; c++) begin
            if (rst_req) begin
                sb_on = 0; do_reset(); sb_on = 1;
            end
            if ($urandom % 64 == 0) ivl_sel = 2'($urandom);
            if ($urandom % 32 == 0) irq_en = ~irq_en;
            flag_clr   = ($urandom % 8 == 0);
            tb_clr     = ($urandom % 200 == 0);
            wd_start   = ($urandom % 50 == 0);
            wd_kick    = ($urandom % 20 == 0);
            wd_sel     = 2'($urandom);
            wd_src_sub = 1'($urandom);
            sub_tick   = ($urandom % 3 == 0);
            tick();
        end
        sb_on = 0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule